// File: doc/BRIEF.md
# Width-Converting DMA Channel Buffer

This block is the data buffer inside one DMA channel. It sits between the source-read side and the destination-write side, and it holds up to four 32-bit words. The two sides may move 8-bit, 16-bit or 32-bit quantities independently of each other. The buffer therefore works at byte granularity internally. Narrow source reads are packed into the byte stream, and the destination side takes out whatever width it asks for, so that four byte writes can leave as one word, or one word write can leave as two halfwords.

Each side presents a request with a size code. The buffer answers in the same cycle with an accept strobe, and the accepted transfer takes effect at the next rising clock edge. Read data is presented combinationally with the accept. A selectable byte ordering decides which lanes of a data bus carry the lowest-addressed byte. A flush input discards all buffered bytes and any half-packed word in a single cycle. Occupancy is reported in bytes, together with full and empty flags.

Top module: `dma_pack_fifo`

## Requirements
- R1: After reset the byte level is 0, `empty` is 1, `full` is 0, and the byte order is little-endian.
- R2: A write request is accepted (`wr_ok`=1) exactly when its size code is valid, `flush` is low, and level plus transfer bytes is at most 16. Accepted bytes raise the level at the next edge. A refused write changes nothing.
- R3: A read request is accepted (`rd_ok`=1) exactly when its size code is valid, `flush` is low, and the level is at least the transfer bytes. An accepted read lowers the level at the next edge. A refused read changes nothing.
- R4: Size code 0 moves 1 byte, code 1 moves 2 bytes and code 2 moves 4 bytes. Code 3 is never accepted, and it raises `size_err` in the same cycle for any active request that carries it.
- R5: In little-endian order the lowest-addressed byte of a transfer sits in bits 7:0. Narrow values are right-justified. `rd_data` bits above the transfer width, and all of `rd_data` when no read is accepted, are 0.
- R6: In big-endian order the lowest-addressed byte is the most significant byte of the n-byte value. For a word this is bits 31:24, and for a halfword it is bits 15:8.
- R7: The byte order in use is the value of `endian_be` (1 = big-endian) sampled at the previous rising edge. A transfer in the same cycle as a change of `endian_be` still uses the old order.
- R8: Bytes leave in the order they entered, across any mix of write and read widths.
- R9: While `flush` is high, both requests are refused, and the level is 0 after the edge. A partially filled word is discarded.
- R10: `level` counts the stored bytes (0 to 16), `full` is 1 exactly at level 16, and `empty` is 1 exactly at level 0.
- R11: A read and a write in the same cycle are each judged on the level at the start of the cycle, and both take effect at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flush | input | 1 | Discard all buffered bytes |
| endian_be | input | 1 | Byte order select, 1 = big-endian, registered |
| wr_valid | input | 1 | Write request |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write data, narrow values right-justified |
| wr_ok | output | 1 | Write accepted this cycle |
| rd_valid | input | 1 | Read request |
| rd_size | input | 2 | Read size code |
| rd_data | output | 32 | Read data, valid when `rd_ok` is 1 |
| rd_ok | output | 1 | Read accepted this cycle |
| size_err | output | 1 | An active request carries size code 3 |
| level | output | 5 | Stored byte count |
| full | output | 1 | Level is 16 |
| empty | output | 1 | Level is 0 |

## Verification
The bench builds the block with its default depth of four words, which gives 16 byte slots and a 4-bit slot pointer. With only 16 slots, random traffic quickly reaches both the full and empty boundaries and wraps the pointer many times. It also produces words that straddle the wrap point and are assembled from bytes written in different widths and byte orders. Mixing halfword and word requests near a level of 14 or 2 exercises the cases where only some sizes are still allowed.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

  localparam int LANE_BYTES = 4;

  typedef enum logic [1:0] {
    XFER_BYTE = 2'd0,
    XFER_HALF = 2'd1,
    XFER_WORD = 2'd2,
    XFER_BAD  = 2'd3
  } xfer_size_e;

  // Byte count moved by a size code; zero marks an illegal code.
  function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
    case (xfer_size_e'(code))
      XFER_BYTE: size_to_bytes = 3'd1;
      XFER_HALF: size_to_bytes = 3'd2;
      XFER_WORD: size_to_bytes = 3'd4;
      default:   size_to_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dpf_lane_order.sv
// Converts between a right-justified bus value and address-ordered bytes.
// The mapping is its own inverse, so one instance serves each direction.
module dpf_lane_order
  import dpf_pkg::*;
(
  input  logic                      big_endian,
  input  logic [2:0]                count,
  input  logic [LANE_BYTES*8-1:0]   din,
  output logic [LANE_BYTES*8-1:0]   dout
);

  always_comb begin
    dout = '0;
    for (int j = 0; j < LANE_BYTES; j++) begin
      if (j < int'(count)) begin
        if (big_endian) begin
          dout[8*j +: 8] = din[8*(int'(count) - 1 - j) +: 8];
        end else begin
          dout[8*j +: 8] = din[8*j +: 8];
        end
      end
    end
  end

endmodule

// File: rtl/dpf_byte_store.sv
// Circular byte storage: up to LANE_BYTES bytes in and out per cycle.
module dpf_byte_store
  import dpf_pkg::*;
#(
  parameter int CAP_BYTES = 16,
  localparam int PTR_W    = $clog2(CAP_BYTES)
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [PTR_W-1:0]          wr_ptr,
  input  logic [2:0]                wr_cnt,
  input  logic [LANE_BYTES*8-1:0]   wr_bytes,
  input  logic [PTR_W-1:0]          rd_ptr,
  output logic [LANE_BYTES*8-1:0]   rd_bytes
);

  logic [CAP_BYTES*8-1:0] cells_flat;

  for (genvar i = 0; i < CAP_BYTES; i++) begin : g_cell
    logic [PTR_W-1:0] offset;
    logic [1:0]       lane;
    logic             hit;
    logic [7:0]       cell_q;

    assign offset = PTR_W'(i) - wr_ptr;
    assign lane   = offset[1:0];
    assign hit    = wr_en && (int'(offset) < int'(wr_cnt));

    always_ff @(posedge clk) begin
      if (hit) begin
        cell_q <= wr_bytes[8*lane +: 8];
      end
    end

    assign cells_flat[8*i +: 8] = cell_q;
  end

  always_comb begin
    rd_bytes = '0;
    for (int k = 0; k < LANE_BYTES; k++) begin
      rd_bytes[8*k +: 8] = cells_flat[8*int'(rd_ptr + PTR_W'(k)) +: 8];
    end
  end

endmodule

// File: rtl/dpf_level_ctrl.sv
// Admission decisions, byte level and both ring pointers.
module dpf_level_ctrl
  import dpf_pkg::*;
#(
  parameter int CAP_BYTES = 16,
  localparam int PTR_W    = $clog2(CAP_BYTES),
  localparam int LVL_W    = $clog2(CAP_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_valid,
  input  logic [1:0]        wr_size,
  input  logic              rd_valid,
  input  logic [1:0]        rd_size,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic              size_err,
  output logic [2:0]        wr_cnt,
  output logic [2:0]        rd_cnt,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [LVL_W-1:0]  level
);

  logic [LVL_W-1:0] level_q, level_d;
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic             upd_en;

  assign wr_cnt = size_to_bytes(wr_size);
  assign rd_cnt = size_to_bytes(rd_size);

  always_comb begin
    wr_ok    = wr_valid && !flush && (wr_cnt != 3'd0) &&
               (int'(level_q) + int'(wr_cnt) <= CAP_BYTES);
    rd_ok    = rd_valid && !flush && (rd_cnt != 3'd0) &&
               (int'(level_q) >= int'(rd_cnt));
    size_err = (wr_valid && (wr_size == XFER_BAD)) ||
               (rd_valid && (rd_size == XFER_BAD));
  end

  always_comb begin
    level_d  = level_q;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (flush) begin
      level_d  = '0;
      wr_ptr_d = '0;
      rd_ptr_d = '0;
    end else begin
      if (wr_ok) begin
        wr_ptr_d = wr_ptr_q + PTR_W'(wr_cnt);
      end
      if (rd_ok) begin
        rd_ptr_d = rd_ptr_q + PTR_W'(rd_cnt);
      end
      level_d = level_q + (wr_ok ? LVL_W'(wr_cnt) : '0)
                        - (rd_ok ? LVL_W'(rd_cnt) : '0);
    end
  end

  assign upd_en = flush || wr_ok || rd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (upd_en) begin
      level_q  <= level_d;
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  assign wr_ptr = wr_ptr_q;
  assign rd_ptr = rd_ptr_q;
  assign level  = level_q;

endmodule

// File: rtl/dma_pack_fifo.sv
module dma_pack_fifo
  import dpf_pkg::*;
#(
  parameter int DEPTH_WORDS = 4,
  localparam int CAP_BYTES  = DEPTH_WORDS * LANE_BYTES,
  localparam int PTR_W      = $clog2(CAP_BYTES),
  localparam int LVL_W      = $clog2(CAP_BYTES + 1),
  localparam int DATA_W     = LANE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              endian_be,
  input  logic              wr_valid,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ok,
  input  logic              rd_valid,
  input  logic [1:0]        rd_size,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ok,
  output logic              size_err,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty
);

  logic              be_q, be_d;
  logic [2:0]        wr_cnt, rd_cnt;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [DATA_W-1:0] wr_bytes, rd_bytes, rd_value;

  // Byte-order mode register: follows endian_be one edge later.
  assign be_d = endian_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_q <= 1'b0;
    end else begin
      be_q <= be_d;
    end
  end

  dpf_level_ctrl #(.CAP_BYTES(CAP_BYTES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_valid (wr_valid),
    .wr_size  (wr_size),
    .rd_valid (rd_valid),
    .rd_size  (rd_size),
    .wr_ok    (wr_ok),
    .rd_ok    (rd_ok),
    .size_err (size_err),
    .wr_cnt   (wr_cnt),
    .rd_cnt   (rd_cnt),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .level    (level)
  );

  dpf_lane_order u_wr_order (
    .big_endian (be_q),
    .count      (wr_cnt),
    .din        (wr_data),
    .dout       (wr_bytes)
  );

  dpf_byte_store #(.CAP_BYTES(CAP_BYTES)) u_store (
    .clk      (clk),
    .wr_en    (wr_ok),
    .wr_ptr   (wr_ptr),
    .wr_cnt   (wr_cnt),
    .wr_bytes (wr_bytes),
    .rd_ptr   (rd_ptr),
    .rd_bytes (rd_bytes)
  );

  dpf_lane_order u_rd_order (
    .big_endian (be_q),
    .count      (rd_cnt),
    .din        (rd_bytes),
    .dout       (rd_value)
  );

  assign rd_data = rd_ok ? rd_value : '0;
  assign full    = (level == LVL_W'(CAP_BYTES));
  assign empty   = (level == '0);

endmodule

// File: rtl/dpf_checker.sv
module dpf_checker #(
  parameter int DEPTH_WORDS = 4,
  localparam int CAP_BYTES  = DEPTH_WORDS * 4,
  localparam int LVL_W      = $clog2(CAP_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             wr_valid,
  input logic [1:0]       wr_size,
  input logic             wr_ok,
  input logic             rd_valid,
  input logic [1:0]       rd_size,
  input logic             rd_ok,
  input logic [31:0]      rd_data,
  input logic [LVL_W-1:0] level,
  input logic             full,
  input logic             empty
);

  logic [LVL_W-1:0] wr_n, rd_n;

  always_comb begin
    wr_n = (wr_size == 2'd2) ? LVL_W'(4) : (wr_size == 2'd1) ? LVL_W'(2) : LVL_W'(1);
    rd_n = (rd_size == 2'd2) ? LVL_W'(4) : (rd_size == 2'd1) ? LVL_W'(2) : LVL_W'(1);
  end

  // R1
  a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (level == '0) && empty && !full);

  // R10
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= CAP_BYTES);

  // R10
  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({full, empty}));

  // R2
  a_r2_write_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !rd_ok && !flush) |=> (level == $past(level) + $past(wr_n)));

  // R3
  a_r3_read_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && !wr_ok && !flush) |=> (level == $past(level) - $past(rd_n)));

  // R3
  a_r3_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !rd_ok);

  // R4
  a_r4_bad_size_refused: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_valid && wr_size == 2'd3) |-> !wr_ok) and
    ((rd_valid && rd_size == 2'd3) |-> !rd_ok));

  // R5
  a_r5_idle_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |-> (rd_data == '0));

  // R9
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0) && empty);

  // R11
  a_r11_steady_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ok && !rd_ok && !flush) |=> $stable(level));

endmodule

bind dma_pack_fifo dpf_checker #(.DEPTH_WORDS(DEPTH_WORDS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flush    (flush),
  .wr_valid (wr_valid),
  .wr_size  (wr_size),
  .wr_ok    (wr_ok),
  .rd_valid (rd_valid),
  .rd_size  (rd_size),
  .rd_ok    (rd_ok),
  .rd_data  (rd_data),
  .level    (level),
  .full     (full),
  .empty    (empty)
);

// File: tb/dma_pack_fifo_tb.sv
`timescale 1ns/1ps
module dma_pack_fifo_tb;

  localparam int CAP = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic        endian_be;
  logic        wr_valid;
  logic [1:0]  wr_size;
  logic [31:0] wr_data;
  logic        wr_ok;
  logic        rd_valid;
  logic [1:0]  rd_size;
  logic [31:0] rd_data;
  logic        rd_ok;
  logic        size_err;
  logic [4:0]  level;
  logic        full;
  logic        empty;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] model_q[$];
  bit         mode_ref;

  always #5 clk = ~clk;

  dma_pack_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .endian_be(endian_be),
    .wr_valid(wr_valid), .wr_size(wr_size), .wr_data(wr_data), .wr_ok(wr_ok),
    .rd_valid(rd_valid), .rd_size(rd_size), .rd_data(rd_data), .rd_ok(rd_ok),
    .size_err(size_err), .level(level), .full(full), .empty(empty)
  );

  function automatic int nbytes(input logic [1:0] code);
    case (code)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] expect_read(input int n, input bit be);
    logic [31:0] v = '0;
    for (int k = 0; k < n; k++) begin
      if (be) v[8*(n-1-k) +: 8] = model_q[k];
      else    v[8*k +: 8]       = model_q[k];
    end
    return v;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, got, exp);
    end
  endtask

  // One cycle: drive after negedge, check before posedge, update model at posedge.
  task automatic step(input string tag, input bit wv, input logic [1:0] ws,
                      input logic [31:0] wd, input bit rv, input logic [1:0] rs,
                      input bit fl, input bit be);
    int  nw, nr;
    bit  ewok, erok, eerr;
    logic [31:0] erd;
    wr_valid = wv; wr_size = ws; wr_data = wd;
    rd_valid = rv; rd_size = rs; flush = fl; endian_be = be;
    #2;
    nw   = nbytes(ws);
    nr   = nbytes(rs);
    ewok = wv && !fl && nw != 0 && (model_q.size() + nw <= CAP);
    erok = rv && !fl && nr != 0 && (model_q.size() >= nr);
    eerr = (wv && ws == 2'd3) || (rv && rs == 2'd3);
    erd  = erok ? expect_read(nr, mode_ref) : 32'h0;
    chk({tag, " R2/R4"}, "wr_ok", 32'(wr_ok), 32'(ewok));
    chk({tag, " R3/R4"}, "rd_ok", 32'(rd_ok), 32'(erok));
    chk({tag, " R4"}, "size_err", 32'(size_err), 32'(eerr));
    chk({tag, " R5/R6/R8"}, "rd_data", rd_data, erd);
    chk({tag, " R10"}, "level", 32'(level), 32'(model_q.size()));
    chk({tag, " R10"}, "full", 32'(full), 32'(model_q.size() == CAP));
    chk({tag, " R10"}, "empty", 32'(empty), 32'(model_q.size() == 0));
    @(posedge clk);
    if (fl) begin
      model_q.delete();
    end else begin
      if (erok) for (int k = 0; k < nr; k++) void'(model_q.pop_front());
      if (ewok) begin
        for (int k = 0; k < nw; k++) begin
          if (mode_ref) model_q.push_back(wd[8*(nw-1-k) +: 8]);
          else          model_q.push_back(wd[8*k +: 8]);
        end
      end
    end
    mode_ref = be;
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input bit be);
    step(tag, 0, 2'd0, 32'h0, 0, 2'd0, 0, be);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; flush = 0; endian_be = 0; wr_valid = 0; wr_size = 0;
    wr_data = 0; rd_valid = 0; rd_size = 0; mode_ref = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: reset state
    idle("R1", 0);

    // R7: mode switches one edge late; first word still little-endian
    step("R7", 1, 2'd2, 32'h11223344, 0, 2'd0, 0, 1);
    // read word now in big-endian: bytes 44,33,22,11 -> 0x44332211
    step("R7", 0, 2'd0, 32'h0, 1, 2'd2, 0, 1);
    chk("R7", "be_word", rd_data, 32'h0);
    idle("R7", 0);

    // R8/R5: four bytes packed, read as one little-endian word
    step("R8", 1, 2'd0, 32'hFFFF_FFA1, 0, 2'd0, 0, 0);
    step("R8", 1, 2'd0, 32'h0000_00B2, 0, 2'd0, 0, 0);
    step("R8", 1, 2'd0, 32'h0000_00C3, 0, 2'd0, 0, 0);
    step("R8", 1, 2'd0, 32'h0000_00D4, 0, 2'd0, 0, 0);
    step("R8", 0, 2'd0, 32'h0, 1, 2'd2, 0, 0);

    // R6: big-endian halfwords, read back as bytes and a halfword
    idle("R6", 1);
    step("R6", 1, 2'd1, 32'h0000_5A6B, 0, 2'd0, 0, 1);
    step("R6", 0, 2'd0, 32'h0, 1, 2'd0, 0, 1);
    step("R6", 1, 2'd2, 32'hCAFE_F00D, 0, 2'd0, 0, 1);
    step("R6", 0, 2'd0, 32'h0, 1, 2'd1, 0, 1);
    step("R6", 0, 2'd0, 32'h0, 1, 2'd1, 0, 1);
    step("R3", 0, 2'd0, 32'h0, 1, 2'd2, 0, 1);   // R3: too few bytes
    step("R6", 0, 2'd0, 32'h0, 1, 2'd0, 0, 1);
    step("R3", 0, 2'd0, 32'h0, 1, 2'd0, 0, 1);   // R3: read from empty

    // R4: illegal size code on both sides
    step("R4", 1, 2'd3, 32'h1234_5678, 1, 2'd3, 0, 0);

    // R2/R10: fill to full then one more byte is refused
    for (int i = 0; i < 4; i++) step("R2", 1, 2'd2, 32'h0101_0101 * (i + 1), 0, 2'd0, 0, 0);
    step("R2", 1, 2'd0, 32'h0000_00EE, 0, 2'd0, 0, 0);

    // R11: at full, write refused but read accepted in the same cycle
    step("R11", 1, 2'd2, 32'hDEAD_BEEF, 1, 2'd2, 0, 0);
    // R11: at 12, both accepted together
    step("R11", 1, 2'd2, 32'h8765_4321, 1, 2'd2, 0, 0);
    idle("R11", 0);

    // R9: flush refuses requests and discards a partial word
    step("R9", 0, 2'd0, 32'h0, 1, 2'd2, 0, 0);
    step("R9", 1, 2'd0, 32'h0000_0077, 0, 2'd0, 0, 0);
    step("R9", 1, 2'd0, 32'h0000_0088, 1, 2'd0, 1, 0);
    idle("R9", 0);
    step("R9", 1, 2'd0, 32'h0000_0099, 0, 2'd0, 0, 0);
    step("R9", 0, 2'd0, 32'h0, 1, 2'd0, 0, 0);

    // Random traffic across all widths, orders and boundaries
    for (int i = 0; i < 4000; i++) begin
      bit wv, rv, fl, be;
      logic [1:0] ws, rs;
      wv = ($urandom_range(0, 9) < 6);
      rv = ($urandom_range(0, 9) < 6);
      ws = ($urandom_range(0, 19) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      rs = ($urandom_range(0, 19) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      fl = ($urandom_range(0, 99) == 0);
      be = (((i / 300) % 2) == 1) ? 1'b1 : ($urandom_range(0, 49) == 0);
      step("R8 rand", wv, ws, $urandom, rv, rs, fl, be);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule